// File: doc/BRIEF.md
# Time-Slotted Capture Framebuffer Sequencer

This block lets one external single-port SRAM serve two jobs at once: it stores a live stream of ADC samples and it feeds a 320x240 monochrome display path. It needs no on-chip RAM. All logic runs from one master clock, nominally 18.432 MHz. The clock is cut into a fixed three-cycle period. The first cycle of each period is a write slot, and the next two are read slots. The ADC strobe fires once per period, which gives 6.144 MHz, and that is exactly 320 samples per video line.

In the write slot, the current ADC sample goes straight onto the SRAM data bus at the write address. In each read slot, the bus is released, output-enable is asserted and the pixel at the read address is fetched. The fetched byte is registered and presented with a one-cycle valid pulse. The write and read address counters are independent. Each one steps through one frame (H_PIX x V_LINES locations, 76800 by default) and wraps. The 128 KiB SRAM holds that frame.

Top module: `fb_slot_seq`

## Requirements
- R1: After reset release the slots repeat in a fixed order: write, read, read. The first cycle after release is a write slot.
- R2: `adc_stb_o` is high during the write slot only, so it is high in exactly one cycle out of every three.
- R3: In a write slot, `sram_we_no`=0, `sram_oe_no`=1 and `sram_dq_oe_o`=1. `sram_dq_o` equals `adc_data_i`, and `sram_addr_o` holds the write address. The SRAM stores the sample at the rising edge that ends the slot.
- R4: In a read slot, `sram_we_no`=1, `sram_oe_no`=0, `sram_dq_oe_o`=0, and `sram_addr_o` holds the read address.
- R5: The write address starts at 0 and advances by one after each write slot. It goes from H_PIX*V_LINES-1 back to 0, and it never leaves that range.
- R6: The read address starts at 0 and advances by one after each read slot. It wraps in the same way, independently of the write address.
- R7: `sram_dq_i` is sampled at the edge that ends each read slot. It appears on `pix_o` in the following cycle, with `pix_vld_o` high for that one cycle. `pix_vld_o` is low in every other cycle.
- R8: While `rst_ni` is low, no SRAM access takes place (`sram_we_no`=1, `sram_oe_no`=1, `sram_dq_oe_o`=0), `adc_stb_o`=0 and `pix_vld_o`=0. Both counters return to 0, so `sram_addr_o`=0. The SRAM contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_data_i | input | DATA_W | ADC sample, used in the write slot |
| adc_stb_o | output | 1 | Sample strobe, one cycle in three |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_dq_o | output | DATA_W | SRAM write data |
| sram_dq_i | input | DATA_W | SRAM read data |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| pix_o | output | DATA_W | Fetched pixel |
| pix_vld_o | output | 1 | Pixel valid pulse |

## Verification
The strobe, the bus controls, the address and the write data are decoded from registered state. They are therefore due in the same cycle as the slot they belong to, and the bench checks them 1 ns after the falling edge, once the ADC data for that slot has been applied.

A fetched pixel is due exactly one cycle after its read slot. The driver queues the expected byte from its own shadow of the SRAM during the read slot. The monitor removes it at the next falling edge, and it requires the valid pulse exactly when an item is waiting.

A smaller frame is used so that both counters wrap several times. A reset in mid-run checks that the counters restart while the stored data is kept.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {
    SLOT_WR  = 2'd0,
    SLOT_RD0 = 2'd1,
    SLOT_RD1 = 2'd2
  } slot_e;
endpackage

// File: rtl/fb_slot_timer.sv
module fb_slot_timer
  import fb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_e slot_o
);
  slot_e slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= SLOT_WR;
    else begin
      unique case (slot_q)
        SLOT_WR:  slot_q <= SLOT_RD0;
        SLOT_RD0: slot_q <= SLOT_RD1;
        default:  slot_q <= SLOT_WR;
      endcase
    end
  end

  assign slot_o = slot_q;

  // R1
  legal_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q == SLOT_RD1 |=> slot_q == SLOT_WR);
endmodule

// File: rtl/fb_wrap_ctr.sv
module fb_wrap_ctr #(
  parameter int LIMIT = 76800,
  parameter int W     = $clog2(LIMIT)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam bit           POW2 = (LIMIT & (LIMIT - 1)) == 0 && LIMIT == (1 << W);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  generate
    if (POW2) begin : g_natural
      assign cnt_nxt = cnt_q + 1'b1;
    end else begin : g_cmp
      assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R5 R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
  // R5 R6
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < LIMIT);
endmodule

// File: rtl/fb_rd_capture.sv
module fb_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] pix_o,
  output logic              vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) pix_o <= dq_i;
    end
  end
endmodule

// File: rtl/fb_slot_seq.sv
module fb_slot_seq
  import fb_pkg::*;
#(
  parameter int H_PIX    = 320,
  parameter int V_LINES  = 240,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = $clog2(H_PIX * V_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_stb_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] pix_o,
  output logic              pix_vld_o
);
  localparam int FRAME_PIX = H_PIX * V_LINES;

  slot_e             slot;
  logic              wr_slot, rd_slot;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  fb_slot_timer i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot)
  );

  // gate with reset so nothing reaches the SRAM while held
  assign wr_slot = rst_ni && (slot == SLOT_WR);
  assign rd_slot = rst_ni && (slot != SLOT_WR);

  fb_wrap_ctr #(.LIMIT(FRAME_PIX), .W(ADDR_W)) i_wr_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (wr_slot),
    .cnt_o  (wr_addr)
  );

  fb_wrap_ctr #(.LIMIT(FRAME_PIX), .W(ADDR_W)) i_rd_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (rd_slot),
    .cnt_o  (rd_addr)
  );

  fb_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (rd_slot),
    .dq_i   (sram_dq_i),
    .pix_o  (pix_o),
    .vld_o  (pix_vld_o)
  );

  assign adc_stb_o    = wr_slot;
  assign sram_addr_o  = wr_slot ? wr_addr : rd_addr;
  assign sram_dq_o    = adc_data_i;
  assign sram_dq_oe_o = wr_slot;
  assign sram_we_no   = !wr_slot;
  assign sram_oe_no   = !rd_slot;

  // R2
  stb_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_stb_o |=> !adc_stb_o ##1 !adc_stb_o ##1 adc_stb_o);
  // R3
  no_bus_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no && sram_dq_oe_o);
  // R4
  read_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> sram_we_no && !sram_dq_oe_o);
  // R7
  vld_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> $past(!sram_oe_no));
  // R7
  vld_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |=> pix_vld_o);
endmodule

// File: tb/test_fb_slot_seq.sv
`timescale 1ns/1ps
module test_fb_slot_seq;
  localparam int H = 8;
  localparam int V = 3;
  localparam int N = H * V;
  localparam int DW = 8;
  localparam int AW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] adc_data_i = '0;
  logic          adc_stb_o;
  logic [AW-1:0] sram_addr_o;
  logic [DW-1:0] sram_dq_o, sram_dq_i;
  logic          sram_dq_oe_o, sram_we_no, sram_oe_no;
  logic [DW-1:0] pix_o;
  logic          pix_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] shadow [0:(1<<AW)-1];

  always #2.5 clk_i = ~clk_i;

  fb_slot_seq #(.H_PIX(H), .V_LINES(V), .DATA_W(DW)) i_fb_slot_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .adc_data_i(adc_data_i), .adc_stb_o(adc_stb_o),
    .sram_addr_o(sram_addr_o), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i),
    .sram_dq_oe_o(sram_dq_oe_o), .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no),
    .pix_o(pix_o), .pix_vld_o(pix_vld_o)
  );

  // SRAM model
  always @(posedge clk_i) if (!sram_we_no) mem[sram_addr_o] <= sram_dq_o;
  assign sram_dq_i = !sram_oe_no ? mem[sram_addr_o] : 8'hEE;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] sample(input int i);
    return DW'((i * 37 + 11) ^ (i >> 2));
  endfunction

  // monitor: pixel scoreboard (R7)
  always @(negedge clk_i) begin
    chk("R7 vld", int'(pix_vld_o), int'(q.size() != 0));
    if (pix_vld_o && q.size() != 0) chk("R7 pix", int'(pix_o), int'(q.pop_front()));
  end

  task automatic check_reset();
    chk("R8 stb", int'(adc_stb_o), 0);
    chk("R8 we_n", int'(sram_we_no), 1);
    chk("R8 oe_n", int'(sram_oe_no), 1);
    chk("R8 dq_oe", int'(sram_dq_oe_o), 0);
    chk("R8 addr", int'(sram_addr_o), 0);
    chk("R8 vld", int'(pix_vld_o), 0);
  endtask

  // driver: release at a negedge, then run cycles
  task automatic run(input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      int ph = k % 3;
      int per = k / 3;
      adc_data_i = sample(per);
      #1;
      if (ph == 0) begin
        int wa = per % N;
        chk("R1/R2 stb", int'(adc_stb_o), 1);
        chk("R3 we_n", int'(sram_we_no), 0);
        chk("R3 oe_n", int'(sram_oe_no), 1);
        chk("R3 dq_oe", int'(sram_dq_oe_o), 1);
        chk("R3 dq", int'(sram_dq_o), int'(adc_data_i));
        chk("R5 waddr", int'(sram_addr_o), wa);
        shadow[wa] = adc_data_i;
      end else begin
        int ra = (2 * per + ph - 1) % N;
        chk("R1/R2 stb", int'(adc_stb_o), 0);
        chk("R4 we_n", int'(sram_we_no), 1);
        chk("R4 oe_n", int'(sram_oe_no), 0);
        chk("R4 dq_oe", int'(sram_dq_oe_o), 0);
        chk("R6 raddr", int'(sram_addr_o), ra);
        q.push_back(shadow[ra]);
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = DW'(i) ^ 8'h5A;
      shadow[i] = DW'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;
    run(200);          // write wraps ~2.8x, read wraps ~5.5x
    #3;
    rst_ni = 1'b0;     // mid-run reset: counters restart, SRAM kept
    q.delete();
    @(negedge clk_i);
    check_reset();
    @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;
    run(40);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule